// File: doc/BRIEF.md
# Scan-Port Configuration Programmer

This block is a four-wire serial test port, following IEEE 1149.1, that serves only to load and check a device's configuration. The device has no boundary-scan cells. A host steps the 16-state port controller with TMS on rising TCK edges and shifts an opcode into a 4-bit instruction register. That opcode picks one of three data paths between TDI and TDO: a one-bit bypass stage, a 32-bit identification word, or a user configuration register.

To set up the device, the host selects the user register and shifts in a new image. It then issues the program opcode and passes through Run-Test/Idle. This starts a timed write into a modelled nonvolatile store, and a busy flag stays up while the write is in progress. When busy drops, the store's contents appear on `cfg_out`, which drives the configured circuitry. Each Capture-DR on the user register loads the stored image, so a later shift returns the current configuration for checking. `trst` is a synchronous power-up reset. It also reloads the store with its factory image.

Top module: `cfg_scan_port`

## Requirements
- R1: Five consecutive rising TCK edges with TMS high bring the controller to Test-Logic-Reset from any state.
- R2: In Test-Logic-Reset the instruction register takes the identify opcode 0010 when the ID register is fitted, and 1111 otherwise. A following data scan then returns the ID word without any instruction scan.
- R3: In Capture-IR the instruction shift stage loads 0001, so the first four bits out of an instruction scan are 1, 0, 0, 0.
- R4: Opcodes 1111 (bypass), 0000 and 0011 (boundary-scan operations) and every undefined opcode select a one-bit bypass stage. That stage captures 0 and delays TDI by exactly one shift.
- R5: Opcode 0010 selects the 32-bit ID register, which shifts out `ID_VALUE` LSB first.
- R6: Opcode 1000 selects the `USER_W`-bit user register. Capture-DR loads it from the store, so a scan returns the stored image LSB first. Update-DR keeps the shifted-in word as the image to program.
- R7: Shifting or updating the user register never changes `cfg_out` or the stored image.
- R8: Entering Run-Test/Idle with opcode 1001 active sets `prog_busy` on the next rising edge. The flag stays high for `PROG_CYCLES` edges, and `cfg_out` takes the last updated user word on the edge where it clears. Staying in Run-Test/Idle does not start a second write.
- R9: TDO and its enable change only on falling TCK edges. The enable is high only in Shift-IR and Shift-DR, and TDO is 0 while it is low.
- R10: While `trst` is high on a rising edge, the controller goes to Test-Logic-Reset, busy clears, and the store and `cfg_out` return to `CFG_INIT`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst | input | 1 | Synchronous active-high reset |
| tms | input | 1 | Mode select, sampled on rising TCK |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, updated on falling TCK |
| tdo_oe | output | 1 | TDO drive enable (low means tri-stated) |
| prog_busy | output | 1 | Nonvolatile write in progress |
| cfg_out | output | USER_W | Stored configuration image |

## Verification
The bench builds the port with a 12-bit user register, a six-edge programming time, a non-zero factory image and a custom ID word. With six edges, the whole busy window fits between two instruction scans, so the edge where busy rises and the edge where the store updates can both be checked exactly. The non-zero factory image lets a read-back that returns stale data be told apart from one that returns the new data. The behavioural model tracks every opcode class, including undefined ones. It also covers five-edge escapes from both shift states.

// File: rtl/cfg_scan_pkg.sv
package cfg_scan_pkg;

    localparam int IR_W = 4;
    typedef logic [IR_W-1:0] opcode_t;

    localparam opcode_t OP_EXTEST  = 4'b0000;
    localparam opcode_t OP_IDCODE  = 4'b0010;
    localparam opcode_t OP_SAMPLE  = 4'b0011;
    localparam opcode_t OP_USER    = 4'b1000;
    localparam opcode_t OP_PROG    = 4'b1001;
    localparam opcode_t OP_BYPASS  = 4'b1111;
    localparam opcode_t IR_CAPTURE = 4'b0001;

    typedef enum logic [3:0] {
        ST_TLR, ST_RTI,
        ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PA_DR, ST_EX2_DR, ST_UPD_DR,
        ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PA_IR, ST_EX2_IR, ST_UPD_IR
    } tap_state_e;

    typedef enum logic [1:0] {SEL_BYP, SEL_ID, SEL_USR} dr_sel_e;

    typedef struct packed {
        logic in_tlr;
        logic in_rti;
        logic cap_ir;
        logic shift_ir;
        logic upd_ir;
        logic cap_dr;
        logic shift_dr;
        logic upd_dr;
    } tap_ctl_t;

    function automatic tap_state_e tap_next(tap_state_e s, logic tms);
        case (s)
            ST_TLR:    return tms ? ST_TLR    : ST_RTI;
            ST_RTI:    return tms ? ST_SEL_DR : ST_RTI;
            ST_SEL_DR: return tms ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: return tms ? ST_EX1_DR : ST_SH_DR;
            ST_SH_DR:  return tms ? ST_EX1_DR : ST_SH_DR;
            ST_EX1_DR: return tms ? ST_UPD_DR : ST_PA_DR;
            ST_PA_DR:  return tms ? ST_EX2_DR : ST_PA_DR;
            ST_EX2_DR: return tms ? ST_UPD_DR : ST_SH_DR;
            ST_UPD_DR: return tms ? ST_SEL_DR : ST_RTI;
            ST_SEL_IR: return tms ? ST_TLR    : ST_CAP_IR;
            ST_CAP_IR: return tms ? ST_EX1_IR : ST_SH_IR;
            ST_SH_IR:  return tms ? ST_EX1_IR : ST_SH_IR;
            ST_EX1_IR: return tms ? ST_UPD_IR : ST_PA_IR;
            ST_PA_IR:  return tms ? ST_EX2_IR : ST_PA_IR;
            ST_EX2_IR: return tms ? ST_UPD_IR : ST_SH_IR;
            default:   return tms ? ST_SEL_DR : ST_RTI;
        endcase
    endfunction

    function automatic dr_sel_e dr_decode(opcode_t op, bit has_id);
        if (op == OP_IDCODE && has_id) return SEL_ID;
        if (op == OP_USER)             return SEL_USR;
        return SEL_BYP;
    endfunction

endpackage

// File: rtl/cfg_scan_fsm.sv
module cfg_scan_fsm
    import cfg_scan_pkg::*;
(
    input  logic       tck,
    input  logic       trst,
    input  logic       tms,
    output tap_state_e state,
    output tap_ctl_t   ctl
);

    always_ff @(posedge tck) begin
        if (trst) state <= ST_TLR;
        else      state <= tap_next(state, tms);
    end

    always_comb begin
        ctl          = '0;
        ctl.in_tlr   = (state == ST_TLR);
        ctl.in_rti   = (state == ST_RTI);
        ctl.cap_ir   = (state == ST_CAP_IR);
        ctl.shift_ir = (state == ST_SH_IR);
        ctl.upd_ir   = (state == ST_UPD_IR);
        ctl.cap_dr   = (state == ST_CAP_DR);
        ctl.shift_dr = (state == ST_SH_DR);
        ctl.upd_dr   = (state == ST_UPD_DR);
    end

    // independent run-length of TMS-high samples for the escape check
    logic [2:0] ones_run;
    always_ff @(posedge tck) begin
        if (trst)          ones_run <= '0;
        else if (!tms)     ones_run <= '0;
        else if (ones_run != 3'd5) ones_run <= ones_run + 3'd1;
    end

    assert_tms_escape_R1: assert property (@(posedge tck) disable iff (trst)
        (ones_run == 3'd5) |-> (state == ST_TLR));

endmodule

// File: rtl/cfg_scan_nvstore.sv
module cfg_scan_nvstore #(
    parameter int             W           = 16,
    parameter int             PROG_CYCLES = 64,
    parameter logic [W-1:0]   CFG_INIT    = '0
) (
    input  logic         tck,
    input  logic         trst,
    input  logic         start,
    input  logic [W-1:0] wdata,
    output logic         busy,
    output logic [W-1:0] cells
);

    localparam int CW = $clog2(PROG_CYCLES + 1);

    logic [CW-1:0] left;
    logic [W-1:0]  pend;

    always_ff @(posedge tck) begin
        if (trst) begin
            busy  <= 1'b0;
            left  <= '0;
            pend  <= CFG_INIT;
            cells <= CFG_INIT;
        end else if (busy) begin
            if (left == '0) begin
                busy  <= 1'b0;
                cells <= pend;
            end else begin
                left <= left - 1'b1;
            end
        end else if (start) begin
            busy <= 1'b1;
            left <= CW'(PROG_CYCLES - 1);
            pend <= wdata;
        end
    end

    // separate up-counter measuring how long busy stays high
    logic [CW-1:0] busy_len;
    always_ff @(posedge tck) begin
        if (trst || !busy) busy_len <= '0;
        else               busy_len <= busy_len + 1'b1;
    end

    assert_busy_window_R8: assert property (@(posedge tck) disable iff (trst)
        $fell(busy) |-> (busy_len == CW'(PROG_CYCLES)));

    assert_cells_only_on_commit_R7: assert property (@(posedge tck) disable iff (trst)
        !$stable(cells) |-> $fell(busy));

endmodule

// File: rtl/cfg_scan_port.sv
module cfg_scan_port
    import cfg_scan_pkg::*;
#(
    parameter int                USER_W      = 16,
    parameter logic [31:0]       ID_VALUE    = 32'h0A5C_E03B,
    parameter bit                HAS_ID      = 1'b1,
    parameter int                PROG_CYCLES = 64,
    parameter logic [USER_W-1:0] CFG_INIT    = '0
) (
    input  logic              tck,
    input  logic              trst,
    input  logic              tms,
    input  logic              tdi,
    output logic              tdo,
    output logic              tdo_oe,
    output logic              prog_busy,
    output logic [USER_W-1:0] cfg_out
);

    localparam opcode_t RST_OP = HAS_ID ? OP_IDCODE : OP_BYPASS;

    tap_state_e state;
    tap_ctl_t   ctl;

    cfg_scan_fsm u_fsm (
        .tck   (tck),
        .trst  (trst),
        .tms   (tms),
        .state (state),
        .ctl   (ctl)
    );

    // instruction path
    opcode_t ir, ir_sh;
    always_ff @(posedge tck) begin
        if (trst || ctl.in_tlr) begin
            ir    <= RST_OP;
            ir_sh <= IR_CAPTURE;
        end else begin
            if (ctl.cap_ir)        ir_sh <= IR_CAPTURE;
            else if (ctl.shift_ir) ir_sh <= {tdi, ir_sh[IR_W-1:1]};
            if (ctl.upd_ir)        ir    <= ir_sh;
        end
    end

    dr_sel_e sel;
    assign sel = dr_decode(ir, HAS_ID);

    // bypass stage
    logic byp;
    always_ff @(posedge tck) begin
        if (trst)                                byp <= 1'b0;
        else if (ctl.cap_dr   && sel == SEL_BYP) byp <= 1'b0;
        else if (ctl.shift_dr && sel == SEL_BYP) byp <= tdi;
    end

    // identification register, present only when fitted
    logic id_lsb;
    generate
        if (HAS_ID) begin : g_id
            logic [31:0] id_sh;
            always_ff @(posedge tck) begin
                if (trst)                               id_sh <= ID_VALUE;
                else if (ctl.cap_dr   && sel == SEL_ID) id_sh <= ID_VALUE;
                else if (ctl.shift_dr && sel == SEL_ID) id_sh <= {tdi, id_sh[31:1]};
            end
            assign id_lsb = id_sh[0];
        end else begin : g_no_id
            assign id_lsb = 1'b0;
        end
    endgenerate

    // user configuration register and programming trigger
    logic [USER_W-1:0] usr_sh, usr_hold, cells;
    logic              busy, was_rti, start;

    always_ff @(posedge tck) begin
        if (trst) begin
            usr_sh   <= CFG_INIT;
            usr_hold <= CFG_INIT;
            was_rti  <= 1'b0;
        end else begin
            was_rti <= ctl.in_rti;
            if (ctl.cap_dr && sel == SEL_USR)        usr_sh <= cells;
            else if (ctl.shift_dr && sel == SEL_USR) usr_sh <= {tdi, usr_sh[USER_W-1:1]};
            if (ctl.upd_dr && sel == SEL_USR)        usr_hold <= usr_sh;
        end
    end

    assign start = ctl.in_rti && !was_rti && (ir == OP_PROG) && !busy;

    cfg_scan_nvstore #(
        .W           (USER_W),
        .PROG_CYCLES (PROG_CYCLES),
        .CFG_INIT    (CFG_INIT)
    ) u_store (
        .tck   (tck),
        .trst  (trst),
        .start (start),
        .wdata (usr_hold),
        .busy  (busy),
        .cells (cells)
    );

    assign prog_busy = busy;
    assign cfg_out   = cells;

    // falling-edge output stage
    logic dr_lsb;
    always_comb begin
        case (sel)
            SEL_ID:  dr_lsb = id_lsb;
            SEL_USR: dr_lsb = usr_sh[0];
            default: dr_lsb = byp;
        endcase
    end

    always_ff @(negedge tck) begin
        if (trst) begin
            tdo    <= 1'b0;
            tdo_oe <= 1'b0;
        end else begin
            tdo_oe <= ctl.shift_ir | ctl.shift_dr;
            tdo    <= ctl.shift_ir ? ir_sh[0] : (ctl.shift_dr ? dr_lsb : 1'b0);
        end
    end

    assert_oe_in_shift_R9: assert property (@(posedge tck) disable iff (trst)
        tdo_oe |-> (ctl.shift_ir || ctl.shift_dr));

    assert_quiet_tdo_R9: assert property (@(posedge tck) disable iff (trst)
        !tdo_oe |-> !tdo);

    assert_reset_opcode_R2: assert property (@(posedge tck) disable iff (trst)
        ctl.in_tlr |=> (ir == RST_OP));

    assert_ir_capture_R3: assert property (@(posedge tck) disable iff (trst)
        (ctl.shift_ir && $past(ctl.cap_ir)) |-> (ir_sh == IR_CAPTURE));

endmodule

// File: tb/sim_cfg_scan_port.sv
`timescale 1ns/1ps
module sim_cfg_scan_port;

    localparam int          UW    = 12;
    localparam int          PC    = 6;
    localparam logic [31:0] IDV   = 32'h3B9D_40C5;
    localparam logic [UW-1:0] INIT = 12'h5A3;

    // behavioural state codes
    localparam int TLR=0, RTI=1, SELDR=2, CAPDR=3, SHDR=4, EX1DR=5, PADR=6, EX2DR=7, UPDR=8,
                   SELIR=9, CAPIR=10, SHIR=11, EX1IR=12, PAIR=13, EX2IR=14, UPIR=15;

    logic tck = 1'b0;
    logic trst = 1'b1, tms = 1'b1, tdi = 1'b0;
    logic tdo, tdo_oe, prog_busy;
    logic [UW-1:0] cfg_out;

    always #10 tck = ~tck;

    cfg_scan_port #(
        .USER_W(UW), .ID_VALUE(IDV), .HAS_ID(1'b1), .PROG_CYCLES(PC), .CFG_INIT(INIT)
    ) u0 (
        .tck(tck), .trst(trst), .tms(tms), .tdi(tdi),
        .tdo(tdo), .tdo_oe(tdo_oe), .prog_busy(prog_busy), .cfg_out(cfg_out)
    );

    int checks = 0, fails = 0;
    bit done = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // reference model
    int m_st, m_ir, m_left;
    bit m_busy, m_was_rti, exp_tdo, exp_oe, s_tdo;
    bit irq[$];
    bit drq[$];
    logic [UW-1:0] m_hold, m_store, m_pend;

    function automatic int nxt(int s, bit m);
        case (s)
            TLR:   return m ? TLR   : RTI;
            RTI:   return m ? SELDR : RTI;
            SELDR: return m ? SELIR : CAPDR;
            CAPDR, SHDR: return m ? EX1DR : SHDR;
            EX1DR: return m ? UPDR  : PADR;
            PADR:  return m ? EX2DR : PADR;
            EX2DR: return m ? UPDR  : SHDR;
            UPDR, UPIR: return m ? SELDR : RTI;
            SELIR: return m ? TLR   : CAPIR;
            CAPIR, SHIR: return m ? EX1IR : SHIR;
            EX1IR: return m ? UPIR  : PAIR;
            PAIR:  return m ? EX2IR : PAIR;
            default: return m ? UPIR : SHIR;
        endcase
    endfunction

    task automatic model_reset();
        m_st = TLR; m_ir = 2; m_busy = 0; m_left = 0; m_was_rti = 0;
        m_store = INIT; m_hold = INIT; m_pend = INIT;
        exp_tdo = 0; exp_oe = 0; s_tdo = 0;
        irq = {}; drq = {};
    endtask

    task automatic model_step(input bit m, input bit d);
        int old = m_st;
        logic [UW-1:0] old_store = m_store;
        int sel = (m_ir == 2) ? 1 : (m_ir == 8) ? 2 : 0;
        int old_ir = m_ir;
        bit old_busy = m_busy, old_rti = m_was_rti;
        case (old)
            TLR:   m_ir = 2;
            CAPIR: irq = {1'b1, 1'b0, 1'b0, 1'b0};
            SHIR:  begin void'(irq.pop_front()); irq.push_back(d); end
            UPIR:  begin m_ir = 0; for (int i = 0; i < 4; i++) m_ir += int'(irq[i]) << i; end
            CAPDR: begin
                drq = {};
                if (sel == 1)      for (int i = 0; i < 32; i++) drq.push_back(IDV[i]);
                else if (sel == 2) for (int i = 0; i < UW; i++) drq.push_back(old_store[i]);
                else drq.push_back(1'b0);
            end
            SHDR:  begin void'(drq.pop_front()); drq.push_back(d); end
            UPDR:  if (sel == 2) for (int i = 0; i < UW; i++) m_hold[i] = drq[i];
            default: ;
        endcase
        if (old_busy) begin
            if (m_left == 1) begin m_busy = 0; m_store = m_pend; end
            else m_left--;
        end else if (old == RTI && !old_rti && old_ir == 9) begin
            m_busy = 1; m_left = PC; m_pend = m_hold;
        end
        m_was_rti = (old == RTI);
        m_st = nxt(old, m);
        exp_oe  = (m_st == SHIR) || (m_st == SHDR);
        exp_tdo = (m_st == SHIR) ? irq[0] : (m_st == SHDR) ? drq[0] : 1'b0;
    endtask

    // one TCK period; inputs change just after the falling edge
    task automatic tick(input bit m, input bit d);
        tms = m; tdi = d;
        @(posedge tck); #1;
        chk("R9 tdo held across rising edge", {31'b0, tdo}, {31'b0, s_tdo});
        model_step(m, d);
        @(negedge tck); #1;
        chk("R9 tdo_oe vs model", {31'b0, tdo_oe}, {31'b0, exp_oe});
        chk("R9 tdo vs model",    {31'b0, tdo},    {31'b0, exp_tdo});
        chk("R8 prog_busy vs model", {31'b0, prog_busy}, {31'b0, m_busy});
        chk("R7 cfg_out vs model", {20'b0, cfg_out}, {20'b0, m_store});
        s_tdo = tdo;
    endtask

    task automatic scan_ir(input logic [3:0] op, output logic [3:0] got);
        tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
        for (int i = 0; i < 4; i++) begin
            got[i] = tdo;
            tick(i == 3, op[i]);
        end
        tick(1, 0); tick(0, 0);
    endtask

    task automatic scan_dr(input logic [31:0] din, input int n, output logic [31:0] got);
        got = '0;
        tick(1, 0); tick(0, 0); tick(0, 0);
        for (int i = 0; i < n; i++) begin
            got[i] = tdo;
            tick(i == n - 1, din[i]);
        end
        tick(1, 0); tick(0, 0);
    endtask

    task automatic do_reset();
        trst = 1'b1; tms = 1'b1;
        repeat (3) @(posedge tck);
        @(negedge tck); #1;
        trst = 1'b0;
        model_reset();
    endtask

    initial begin
        logic [3:0]  ir_out;
        logic [31:0] d_out;
        logic [UW-1:0] newcfg = 12'h3C6;

        do_reset();
        chk("R10 cfg_out after reset", {20'b0, cfg_out}, {20'b0, INIT});
        chk("R10 busy after reset", {31'b0, prog_busy}, 32'd0);
        chk("R9 oe low after reset", {31'b0, tdo_oe}, 32'd0);

        tick(0, 0);
        scan_dr(32'h0, 32, d_out);
        chk("R2 ID after reset without IR scan", d_out, IDV);

        scan_ir(4'b1111, ir_out);
        chk("R3 IR capture pattern", {28'b0, ir_out}, 32'h1);
        scan_dr(32'hD, 4, d_out);
        chk("R4 bypass opcode 1111 delay", d_out, 32'hA);

        scan_ir(4'b0000, ir_out);
        chk("R3 IR capture pattern again", {28'b0, ir_out}, 32'h1);
        scan_dr(32'h6, 4, d_out);
        chk("R4 boundary opcode 0000 bypass", d_out, 32'hC);

        scan_ir(4'b0011, ir_out);
        scan_dr(32'h9, 4, d_out);
        chk("R4 boundary opcode 0011 bypass", d_out, 32'h2);

        scan_ir(4'b0101, ir_out);
        scan_dr(32'h7, 4, d_out);
        chk("R4 undefined opcode 0101 bypass", d_out, 32'hE);

        scan_ir(4'b0010, ir_out);
        scan_dr(32'hFFFF_FFFF, 32, d_out);
        chk("R5 ID register contents", d_out, IDV);

        scan_ir(4'b1000, ir_out);
        scan_dr({20'b0, newcfg}, UW, d_out);
        chk("R6 user read returns stored image", d_out, {20'b0, INIT});
        chk("R7 shift leaves cfg_out", {20'b0, cfg_out}, {20'b0, INIT});
        scan_dr(32'h0F0, UW, d_out);
        chk("R7 stored image unchanged by shift", d_out, {20'b0, INIT});
        scan_dr({20'b0, newcfg}, UW, d_out);

        scan_ir(4'b1001, ir_out);
        tick(0, 0);
        chk("R8 busy rises after RTI entry", {31'b0, prog_busy}, 32'd1);
        for (int i = 0; i < PC - 1; i++) tick(0, 0);
        chk("R8 busy still high", {31'b0, prog_busy}, 32'd1);
        chk("R8 store not yet written", {20'b0, cfg_out}, {20'b0, INIT});
        tick(0, 0);
        chk("R8 busy clears", {31'b0, prog_busy}, 32'd0);
        chk("R8 store committed", {20'b0, cfg_out}, {20'b0, newcfg});
        repeat (3) tick(0, 0);
        chk("R8 no retrigger in RTI", {31'b0, prog_busy}, 32'd0);

        scan_ir(4'b1000, ir_out);
        scan_dr(32'h0, UW, d_out);
        chk("R6 read-back of programmed image", d_out, {20'b0, newcfg});

        tick(1, 0); tick(0, 0); tick(0, 0); tick(0, 1); tick(0, 0);
        repeat (5) tick(1, 0);
        chk("R9 oe low after escape", {31'b0, tdo_oe}, 32'd0);
        tick(0, 0);
        scan_dr(32'h0, 32, d_out);
        chk("R1 escape from Shift-DR", d_out, IDV);

        tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 1); tick(0, 0);
        repeat (5) tick(1, 0);
        tick(0, 0);
        scan_dr(32'h0, 32, d_out);
        chk("R1 escape from Shift-IR", d_out, IDV);

        scan_ir(4'b1000, ir_out);
        do_reset();
        chk("R10 store restored by trst", {20'b0, cfg_out}, {20'b0, INIT});
        tick(0, 0);
        scan_dr(32'h0, 32, d_out);
        chk("R10 ID selected after trst", d_out, IDV);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #3_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule